// File: doc/BRIEF.md
# Latched Bidirectional Bus Transceiver

This block joins two bidirectional data buses, called side A and side B, through two independent banks of storage. One bank carries traffic from A to B and the other from B to A. Each direction has its own three active-low controls: a path enable, a gate enable and a drive enable.

A bank is open only while both its path enable and its gate enable are low. While a bank is open, its input is fed straight through to the far side. When the bank closes, it keeps the word it last saw. The far-side driver is switched on only while both the path enable and the drive enable of that direction are low. Otherwise the far side is left undriven.

The block is synchronous. Controls are sampled on the rising clock edge. An open bank loads its input on every edge, so the word held after closing is the one present at the last edge on which the bank was open. A build-time parameter turns on inversion. It complements the word at the output of each bank, so the stored value is always the raw input. Each tri-state side is split into an input bus, an output bus and an output-enable flag. A flag reports when both sides are being driven at the same time.

Top module: `bus_xcvr_latched`

## Requirements
- R1: A synchronous active-low reset clears both storage banks to zero. Driving a side afterwards with its bank closed shows 0x00 in the plain build and 0xFF in the inverting build.
- R2: While eab_n and leab_n are both low, b_out equals a_in in the same cycle. Likewise, a_out follows b_in while eba_n and leba_n are both low.
- R3: When leab_n goes high with eab_n low, the bank holds the a_in value from the last rising edge at which it was open, and b_out shows it. The B-to-A direction behaves the same way through leba_n.
- R4: A rise of eab_n also closes the A-to-B bank. The word held is the one present at the last open edge, and it is shown again once eab_n returns low with leab_n high.
- R5: While a bank is closed, changes on its input bus leave its output word unchanged.
- R6: b_oe is 1 only when eab_n and oeab_n are both low. a_oe is 1 only when eba_n and oeba_n are both low. In every other case the flag is 0 and the side is undriven.
- R7: A bank loads while its output is disabled. The captured word appears once the drive enable is lowered.
- R8: With INVERT=1, every output word is the bitwise complement of the word the plain build would show, in both directions.
- R9: Loading or holding one direction never alters the contents of the other direction's bank.
- R10: contention is 1 exactly when a_oe and b_oe are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous reset, active low |
| a_in | input | WIDTH | Word received from side A |
| a_out | output | WIDTH | Word driven onto side A |
| a_oe | output | 1 | Side A driver on |
| b_in | input | WIDTH | Word received from side B |
| b_out | output | WIDTH | Word driven onto side B |
| b_oe | output | 1 | Side B driver on |
| eab_n | input | 1 | A-to-B path enable, active low |
| leab_n | input | 1 | A-to-B gate enable, active low |
| oeab_n | input | 1 | A-to-B drive enable, active low |
| eba_n | input | 1 | B-to-A path enable, active low |
| leba_n | input | 1 | B-to-A gate enable, active low |
| oeba_n | input | 1 | B-to-A drive enable, active low |
| contention | output | 1 | Both sides driven at once |

## Verification
The bench targets the closing of a bank through the path enable rather than the gate enable. A design that treated the path enable as an output control only would keep loading, and it would show a later word once the path enable returns low.

It also captures a word with the driver off and checks that word later. A design that tied loading to the drive enable would show a stale word.

Both directions are exercised back to back, with both sides held and driven at once. A design that shared storage or crossed the buses would show the other side's word, or it would miss the contention flag.

An inverting instance runs the same sequence alongside the plain one. It catches any inversion that is applied before storage or in one direction only.

// File: rtl/bus_xcvr_latched.sv
module bus_xcvr_latched #(
  parameter int WIDTH  = 8,
  parameter bit INVERT = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] a_in,
  output logic [WIDTH-1:0] a_out,
  output logic             a_oe,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] b_out,
  output logic             b_oe,
  input  logic             eab_n,
  input  logic             leab_n,
  input  logic             oeab_n,
  input  logic             eba_n,
  input  logic             leba_n,
  input  logic             oeba_n,
  output logic             contention
);
  localparam logic [WIDTH-1:0] FLIP = {WIDTH{INVERT}};

  logic             ab_open, ba_open;
  logic [WIDTH-1:0] ab_q, ba_q;

  assign ab_open = ~(eab_n | leab_n);
  assign ba_open = ~(eba_n | leba_n);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ab_q <= '0;
      ba_q <= '0;
    end else begin
      if (ab_open) ab_q <= a_in;
      if (ba_open) ba_q <= b_in;
    end
  end

  assign b_out = (ab_open ? a_in : ab_q) ^ FLIP;
  assign a_out = (ba_open ? b_in : ba_q) ^ FLIP;

  assign b_oe = ~(eab_n | oeab_n);
  assign a_oe = ~(eba_n | oeba_n);

  assign contention = a_oe & b_oe;
endmodule

// File: rtl/bus_xcvr_latched_chk.sv
module bus_xcvr_latched_chk #(
  parameter int WIDTH  = 8,
  parameter bit INVERT = 1'b0
) (
  input logic             clk,
  input logic             rst_n,
  input logic [WIDTH-1:0] a_in,
  input logic [WIDTH-1:0] a_out,
  input logic             a_oe,
  input logic [WIDTH-1:0] b_in,
  input logic [WIDTH-1:0] b_out,
  input logic             b_oe,
  input logic             eab_n,
  input logic             leab_n,
  input logic             oeab_n,
  input logic             eba_n,
  input logic             leba_n,
  input logic             oeba_n,
  input logic             contention
);
  localparam logic [WIDTH-1:0] MASK = {WIDTH{INVERT}};

  // R2
  ab_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!eab_n && !leab_n) |-> (b_out == (a_in ^ MASK)));

  // R2
  ba_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!eba_n && !leba_n) |-> (a_out == (b_in ^ MASK)));

  // R3
  ab_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((eab_n || leab_n) && $past(rst_n) && $past(!eab_n && !leab_n))
      |-> (b_out == ($past(a_in) ^ MASK)));

  // R3
  ba_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((eba_n || leba_n) && $past(rst_n) && $past(!eba_n && !leba_n))
      |-> (a_out == ($past(b_in) ^ MASK)));

  // R5
  ab_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((eab_n || leab_n) && $past(rst_n) && $past(eab_n || leab_n)) |-> $stable(b_out));

  // R5
  ba_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((eba_n || leba_n) && $past(rst_n) && $past(eba_n || leba_n)) |-> $stable(a_out));

  // R6
  b_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eab_n || oeab_n) |-> !b_oe);

  // R6
  a_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eba_n || oeba_n) |-> !a_oe);

  // R10
  clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    contention == (!eab_n && !oeab_n && !eba_n && !oeba_n));
endmodule

bind bus_xcvr_latched bus_xcvr_latched_chk #(.WIDTH(WIDTH), .INVERT(INVERT)) u_chk (.*);

// File: tb/sim_bus_xcvr_latched.sv
`timescale 1ns/1ps
module sim_bus_xcvr_latched;
  localparam int W    = 8;
  localparam int ROWS = 17;
  // row: {req[3:0], ctl[5:0] = eab,leab,oeab,eba,leba,oeba, a_in, b_in, exp_b_out, exp_a_out}
  localparam logic [41:0] VEC [ROWS] = '{
    {4'd1,  6'b010010, 8'hFF, 8'hFF, 8'h00, 8'h00}, // R1 R10 reset contents shown, both driven
    {4'd2,  6'b000111, 8'h3C, 8'h00, 8'h3C, 8'h00}, // R2
    {4'd2,  6'b000111, 8'hA5, 8'h00, 8'hA5, 8'h00}, // R2
    {4'd3,  6'b010111, 8'h0F, 8'h00, 8'hA5, 8'h00}, // R3 close by gate
    {4'd5,  6'b010111, 8'hF0, 8'h00, 8'hA5, 8'h00}, // R5
    {4'd2,  6'b000111, 8'h66, 8'h00, 8'h66, 8'h00}, // R2
    {4'd4,  6'b100111, 8'h99, 8'h00, 8'h00, 8'h00}, // R4 path enable high
    {4'd4,  6'b010111, 8'h11, 8'h00, 8'h66, 8'h00}, // R4 word from last open edge
    {4'd6,  6'b011111, 8'h22, 8'h00, 8'h00, 8'h00}, // R6 drive enable high
    {4'd6,  6'b110111, 8'h22, 8'h00, 8'h00, 8'h00}, // R6 path enable high
    {4'd7,  6'b001111, 8'hC3, 8'h00, 8'h00, 8'h00}, // R7 load with driver off
    {4'd7,  6'b010111, 8'h00, 8'h00, 8'hC3, 8'h00}, // R7 shown later
    {4'd2,  6'b111000, 8'h00, 8'h5A, 8'h00, 8'h5A}, // R2 B to A
    {4'd3,  6'b111010, 8'h00, 8'h00, 8'h00, 8'h5A}, // R3 B to A
    {4'd9,  6'b010010, 8'h77, 8'h88, 8'hC3, 8'h5A}, // R9 R10
    {4'd10, 6'b000000, 8'h12, 8'h34, 8'h12, 8'h34}, // R10 R2
    {4'd9,  6'b010010, 8'h00, 8'h00, 8'h12, 8'h34}  // R9
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic eab_n = 1'b1, leab_n = 1'b1, oeab_n = 1'b1;
  logic eba_n = 1'b1, leba_n = 1'b1, oeba_n = 1'b1;
  logic [W-1:0] a_out, b_out, ai_out, bi_out;
  logic a_oe, b_oe, cont, ai_oe, bi_oe, conti;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bus_xcvr_latched #(.WIDTH(W), .INVERT(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe), .eab_n(eab_n), .leab_n(leab_n),
    .oeab_n(oeab_n), .eba_n(eba_n), .leba_n(leba_n), .oeba_n(oeba_n),
    .contention(cont));

  bus_xcvr_latched #(.WIDTH(W), .INVERT(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .a_out(ai_out), .a_oe(ai_oe),
    .b_in(b_in), .b_out(bi_out), .b_oe(bi_oe), .eab_n(eab_n), .leab_n(leab_n),
    .oeab_n(oeab_n), .eba_n(eba_n), .leba_n(leba_n), .oeba_n(oeba_n),
    .contention(conti));

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [5:0] c, input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk);
    {eab_n, leab_n, oeab_n, eba_n, leba_n, oeba_n} = c;
    a_in = a;
    b_in = b;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #200000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: got hang expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < ROWS; i++) begin
      logic [3:0] rq;
      logic [5:0] c;
      logic [W-1:0] a, b, eb, ea;
      logic xb, xa;
      {rq, c, a, b, eb, ea} = VEC[i];
      drive(c, a, b);
      xb = !c[5] && !c[3];
      xa = !c[2] && !c[0];
      check($sformatf("R6 row %0d b_oe", i), {7'd0, b_oe}, {7'd0, xb});
      check($sformatf("R6 row %0d a_oe", i), {7'd0, a_oe}, {7'd0, xa});
      check($sformatf("R10 row %0d contention", i), {7'd0, cont}, {7'd0, xa && xb});
      if (xb) begin
        check($sformatf("R%0d row %0d b_out", rq, i), b_out, eb);
        check($sformatf("R8 row %0d inverted b_out", i), bi_out, ~eb);
      end
      if (xa) begin
        check($sformatf("R%0d row %0d a_out", rq, i), a_out, ea);
        check($sformatf("R8 row %0d inverted a_out", i), ai_out, ~ea);
      end
    end

    // R1: reset in mid-run clears both banks
    @(negedge clk);
    rst_n = 1'b0;
    drive(6'b111111, 8'hAA, 8'h55);
    @(negedge clk);
    rst_n = 1'b1;
    drive(6'b010010, 8'hAA, 8'h55);
    check("R1 b_out after reset", b_out, 8'h00);
    check("R1 a_out after reset", a_out, 8'h00);
    check("R1 R8 inverted b_out after reset", bi_out, 8'hFF);

    // R6: all idle, nothing driven
    drive(6'b111111, 8'h00, 8'h00);
    check("R6 idle b_oe", {7'd0, b_oe}, 8'h00);
    check("R10 idle contention", {7'd0, cont}, 8'h00);

    // R9: B-to-A load while A-to-B is held
    drive(6'b000111, 8'h81, 8'h00);
    drive(6'b010000, 8'h00, 8'h7E);
    check("R9 b_out kept during B load", b_out, 8'h81);
    check("R2 a_out live", a_out, 8'h7E);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule